// File: doc/BRIEF.md
# NAND Flash Bus Sequencer with Key-Guarded Setup Registers

This block sits between a simple memory-mapped register port and an 8-bit NAND flash device. Software writes a command byte, an address byte or a data byte to one of three bus registers, and the block turns each write into exactly one bus cycle on the flash pins: command latch enable, address latch enable, the write strobe, the read strobe, chip enable and the data lines. A read of the data register produces one read-strobe cycle and returns the byte sampled from the device. The length of every strobe phase is taken from a packed timing register, counted in system clock cycles.

The configuration and timing registers are protected. Each update must be preceded by a write of the unlock key to a lock register, and one protected write uses the key up. A chip-enable register lets software hold chip enable low between cycles. A status register reports the device ready/busy line and whether the sequencer is idle. After a command cycle the block waits a programmable delay and then waits for the device to report ready before it accepts the next bus access.

The request side is a valid/ready port: a request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the requester must hold its fields stable while `req_ready` is low. Bus accesses are held off while a bus cycle is underway. Reads of non-data registers are also held off while a data read is underway, so the two sources of read responses never collide. Other register accesses are taken at once, even during a bus cycle. Responses have no back-pressure: `rsp_valid` is a one-cycle pulse that carries `rsp_rdata`.

Top module: `nand_seq_top`

## Requirements
- R1: After reset all strobes are inactive (CLE and ALE low, write and read strobes high, chip enable high, data bus not driven), the sequencer reports idle, the configuration register reads 0, the timing register reads `TIME_RESET` and the chip-enable register reads 1. Register offsets: 0 command, 1 address, 2 data, 3 configuration, 4 timing, 5 lock, 6 chip enable, 7 status.
- R2: A write to offset 0 runs one command cycle. CLE is high and the write strobe is low for the write-pulse count of clocks, with the low byte driven on the bus. CLE stays high with the strobe high for the write-hold count. The sequencer then waits the busy-after-write count and then stays busy until the device ready line (1 = ready) is high at a clock edge. The sequencer reports busy from the clock after acceptance until it returns to idle.
- R3: A write to offset 1 runs one address cycle with the same strobe timing as R2 but with ALE instead of CLE, and the bus carries bits [7:0] of the written value. It ends after the write-hold phase, with no ready wait.
- R4: A write to offset 2 runs one data-write cycle with neither CLE nor ALE, ending after the write-hold phase.
- R5: A read of offset 2 drives the read strobe low for the read-pulse count of clocks and captures the bus at the edge that ends that phase. The strobe then stays high for the larger of the read-hold and read-to-high-Z counts. The captured byte is returned in `rsp_rdata[7:0]` with `rsp_valid` in the first idle clock after the cycle.
- R6: Timing word fields: write pulse [3:0], write hold [7:4], read pulse [11:8], read hold [15:12], read-to-high-Z [18:16], busy-after-write [23:19], chip-enable setup [25:24]. A strobe-phase field of 0 lasts one clock. When chip enable is not being forced, a nonzero setup field adds that many clocks with only chip enable low before the strobes. A setup field of 0 adds none.
- R7: A write to offset 3 or 4 takes effect only if the most recent write to offset 5 carried `KEY` and no protected write has happened since. Every protected write uses up the key, whether or not it took effect. A lock write with any other value withdraws the key.
- R8: A command write with low byte 0xFF withdraws any pending key and still runs a normal command cycle.
- R9: Writing 0 in bit 0 of offset 6 holds chip enable low while idle. Writing 1 releases it. While chip enable is held, no setup phase is inserted.
- R10: Reads of registers other than the data register return their value with `rsp_valid` in the clock after acceptance. The status word has bit 0 = device ready line and bit 1 = sequencer idle, as sampled in the accepting clock.
- R11: `req_ready` is low while the sequencer is busy and the request is a bus access (write to offset 0-2 or read of offset 2), or while a data read is underway and the request is any read. All other requests are accepted at once.
- R12: The configuration register stores four bits: bit 3 write protect, bit 2 large page, bit 1 four address cycles, bit 0 16-bit bus. They read back unchanged and do not alter any bus cycle, which stays 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | DATA_W | Write value |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | DATA_W | Read response value |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 8 | Bus value driven during writes |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Bus value from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| ctrl_ready | output | 1 | Sequencer idle |

## Verification
The bench builds the block with `DATA_W` of 32, the default key and a reset timing word of write pulse 2, write hold 1, read pulse 2, read hold 1, busy-after-write 2 and no chip-enable setup. With these values the first bus cycles run before any unlock has happened. It then programs a timing word with a two-clock setup phase and a read-to-high-Z count above the read hold, and later an all-zero word. Together these reach the setup insertion, the longer turnaround and the one-clock floor on each phase. Holding the device ready line low during a command cycle keeps the sequencer in its ready wait long enough to observe stalled bus requests and a status read of busy.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int REG_AW = 3;
  localparam int CFG_W  = 4;
  localparam int CNT_W  = 5;
  localparam int BYTE_W = 8;
  localparam int TIME_W = 26;

  localparam logic [REG_AW-1:0] REG_CMD  = 3'd0;
  localparam logic [REG_AW-1:0] REG_ADDR = 3'd1;
  localparam logic [REG_AW-1:0] REG_DATA = 3'd2;
  localparam logic [REG_AW-1:0] REG_CFG  = 3'd3;
  localparam logic [REG_AW-1:0] REG_TIME = 3'd4;
  localparam logic [REG_AW-1:0] REG_LOCK = 3'd5;
  localparam logic [REG_AW-1:0] REG_CE   = 3'd6;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd7;

  localparam logic [BYTE_W-1:0] CMD_RESET = 8'hFF;

  // field order is the register bit layout, most significant first
  typedef struct packed {
    logic [1:0] tcea;
    logic [4:0] twb;
    logic [2:0] trhz;
    logic [3:0] treh;
    logic [3:0] trp;
    logic [3:0] twh;
    logic [3:0] twp;
  } timing_t;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WDATA, OP_RDATA} op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CE, PH_WLO, PH_WHI, PH_WB, PH_RB, PH_RLO, PH_RHI
  } phase_e;

  // counter reload for a phase of f clocks, with 0 treated as 1
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int                 DATA_W     = 32,
  parameter logic [DATA_W-1:0]  KEY        = 32'h0000_A25E,
  parameter logic [TIME_W-1:0]  TIME_RESET = 26'h0101212
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              key_clear,
  output logic [CFG_W-1:0]  cfg,
  output timing_t           timing,
  output logic              ce_bit
);
  logic armed;
  logic prot_wr;

  assign prot_wr = wr_en && (idx == REG_CFG || idx == REG_TIME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      cfg    <= '0;
      timing <= timing_t'(TIME_RESET);
      ce_bit <= 1'b1;
    end else begin
      if (key_clear) begin
        armed <= 1'b0;
      end else if (wr_en && idx == REG_LOCK) begin
        armed <= (wdata == KEY);
      end else if (prot_wr) begin
        armed <= 1'b0;
      end
      if (prot_wr && armed && idx == REG_CFG) cfg <= wdata[CFG_W-1:0];
      if (prot_wr && armed && idx == REG_TIME) timing <= timing_t'(wdata[TIME_W-1:0]);
      if (wr_en && idx == REG_CE) ce_bit <= wdata[0];
    end
  end
endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
  import nand_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               op_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  timing_t           tim_in,
  input  logic              ce_force,
  input  logic              dev_rb,
  input  logic [BYTE_W-1:0] dq_in,
  output logic              busy,
  output logic              rd_op,
  output logic              done,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              ce_n,
  output logic              dq_oe,
  output logic [BYTE_W-1:0] dq_out
);
  phase_e            ph;
  logic [CNT_W-1:0]  cnt;
  op_e               op;
  logic [BYTE_W-1:0] byt;
  timing_t           tim;

  phase_e            start_ph, body_ph;
  logic [CNT_W-1:0]  start_cnt, body_cnt, rhi_len;
  logic              wr_phase;

  // first strobe phase for a new request, from the live inputs
  always_comb begin
    if (op_in == OP_RDATA) begin
      start_ph  = PH_RLO;
      start_cnt = span(CNT_W'(tim_in.trp));
    end else begin
      start_ph  = PH_WLO;
      start_cnt = span(CNT_W'(tim_in.twp));
    end
  end

  // first strobe phase after a setup phase, from the latched request
  always_comb begin
    if (op == OP_RDATA) begin
      body_ph  = PH_RLO;
      body_cnt = span(CNT_W'(tim.trp));
    end else begin
      body_ph  = PH_WLO;
      body_cnt = span(CNT_W'(tim.twp));
    end
  end

  assign rhi_len = (CNT_W'(tim.treh) >= CNT_W'(tim.trhz)) ? CNT_W'(tim.treh) : CNT_W'(tim.trhz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      op      <= OP_CMD;
      byt     <= '0;
      tim     <= '0;
      done    <= 1'b0;
      rd_byte <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            op  <= op_in;
            byt <= byte_in;
            tim <= tim_in;
            if (!ce_force && tim_in.tcea != '0) begin
              ph  <= PH_CE;
              cnt <= span(CNT_W'(tim_in.tcea));
            end else begin
              ph  <= start_ph;
              cnt <= start_cnt;
            end
          end
        end
        PH_RB: begin
          if (dev_rb) ph <= PH_IDLE;
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            case (ph)
              PH_CE: begin
                ph  <= body_ph;
                cnt <= body_cnt;
              end
              PH_WLO: begin
                ph  <= PH_WHI;
                cnt <= span(CNT_W'(tim.twh));
              end
              PH_WHI: begin
                if (op == OP_CMD) begin
                  ph  <= PH_WB;
                  cnt <= span(CNT_W'(tim.twb));
                end else begin
                  ph <= PH_IDLE;
                end
              end
              PH_WB:  ph <= PH_RB;
              PH_RLO: begin
                rd_byte <= dq_in;
                ph      <= PH_RHI;
                cnt     <= span(rhi_len);
              end
              PH_RHI: begin
                ph   <= PH_IDLE;
                done <= 1'b1;
              end
              default: ph <= PH_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign busy     = (ph != PH_IDLE);
  assign rd_op    = busy && (op == OP_RDATA);
  assign wr_phase = (ph == PH_WLO) || (ph == PH_WHI);
  assign cle      = wr_phase && (op == OP_CMD);
  assign ale      = wr_phase && (op == OP_ADDR);
  assign we_n     = (ph != PH_WLO);
  assign re_n     = (ph != PH_RLO);
  assign dq_oe    = wr_phase;
  assign dq_out   = byt;
  assign ce_n     = !(ce_force || busy);
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int                 DATA_W     = 32,
  parameter logic [DATA_W-1:0]  KEY        = 32'h0000_A25E,
  parameter logic [TIME_W-1:0]  TIME_RESET = 26'h0101212
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_ce_n,
  output logic [BYTE_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [BYTE_W-1:0] nand_dq_in,
  input  logic              nand_rb,
  output logic              ctrl_ready
);
  logic              eng_acc, take, wr, rd, start;
  logic              busy, rd_op, eng_done, key_clear;
  logic [BYTE_W-1:0] rd_byte;
  logic [CFG_W-1:0]  cfg;
  timing_t           timing;
  logic              ce_bit;
  op_e               op_sel;
  logic              imm_v;
  logic [DATA_W-1:0] imm_d, rd_mux;

  assign eng_acc   = req_write ? (req_addr <= REG_DATA) : (req_addr == REG_DATA);
  assign req_ready = !(busy && (eng_acc || (!req_write && rd_op)));
  assign take      = req_valid && req_ready;
  assign wr        = take && req_write;
  assign rd        = take && !req_write;
  assign start     = take && eng_acc;
  assign key_clear = wr && (req_addr == REG_CMD) && (req_wdata[BYTE_W-1:0] == CMD_RESET);

  always_comb begin
    if (!req_write)                  op_sel = OP_RDATA;
    else if (req_addr == REG_CMD)    op_sel = OP_CMD;
    else if (req_addr == REG_ADDR)   op_sel = OP_ADDR;
    else                             op_sel = OP_WDATA;
  end

  nand_seq_regs #(
    .DATA_W(DATA_W), .KEY(KEY), .TIME_RESET(TIME_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .idx(req_addr), .wdata(req_wdata),
    .key_clear(key_clear), .cfg(cfg), .timing(timing), .ce_bit(ce_bit)
  );

  nand_seq_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_sel),
    .byte_in(req_wdata[BYTE_W-1:0]), .tim_in(timing), .ce_force(!ce_bit),
    .dev_rb(nand_rb), .dq_in(nand_dq_in), .busy(busy), .rd_op(rd_op),
    .done(eng_done), .rd_byte(rd_byte), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .ce_n(nand_ce_n), .dq_oe(nand_dq_oe),
    .dq_out(nand_dq_out)
  );

  always_comb begin
    case (req_addr)
      REG_CFG:  rd_mux = DATA_W'(cfg);
      REG_TIME: rd_mux = DATA_W'(TIME_W'(timing));
      REG_CE:   rd_mux = DATA_W'(ce_bit);
      REG_STAT: rd_mux = DATA_W'({!busy, nand_rb});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_v <= 1'b0;
      imm_d <= '0;
    end else begin
      imm_v <= rd && !eng_acc;
      imm_d <= rd_mux;
    end
  end

  assign rsp_valid  = imm_v || eng_done;
  assign rsp_rdata  = eng_done ? DATA_W'(rd_byte) : imm_d;
  assign ctrl_ready = !busy;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic ce_n,
  input logic dq_oe,
  input logic ctrl_ready
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R9
  ce_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);

  // R2
  busy_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ctrl_ready);

  // R11
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> !ctrl_ready);

  // R5
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> re_n);

  // R6
  ce_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ready |-> !ce_n);
endmodule

bind nand_seq_top nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
  .ce_n(nand_ce_n), .dq_oe(nand_dq_oe), .ctrl_ready(ctrl_ready)
);

// File: tb/sim_nand_seq_top.sv
module sim_nand_seq_top;
  localparam logic [25:0] TRST = 26'h0101212;
  localparam logic [31:0] KEYV = 32'h0000_A25E;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_write;
  logic [2:0]  req_addr;
  logic [31:0] req_wdata;
  logic [7:0]  nand_dq_in;
  logic        nand_rb;
  logic        req_ready, rsp_valid, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic        nand_ce_n, nand_dq_oe, ctrl_ready;
  logic [31:0] rsp_rdata;
  logic [7:0]  nand_dq_out;

  nand_seq_top #(.DATA_W(32), .KEY(KEYV), .TIME_RESET(TRST)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .ctrl_ready(ctrl_ready)
  );

  typedef struct {bit cle; bit ale; bit we_n; bit re_n; bit oe; bit rsp_after;} slot_t;
  slot_t       q[$];
  bit          wait_rb, m_rd_op, m_armed, m_ce, cur_rsp, last_acc;
  logic [31:0] cur_data;
  logic [3:0]  m_cfg;
  logic [25:0] m_time;
  logic [7:0]  m_byte, m_rbyte;
  int          n_chk, n_fail;
  string       tag;

  function automatic logic [25:0] pack(int wp, int wh, int rp, int reh, int rhz, int wb, int cea);
    return {2'(cea), 5'(wb), 3'(rhz), 4'(reh), 4'(rp), 4'(wh), 4'(wp)};
  endfunction

  task automatic push_n(int n, bit c, bit a, bit w, bit r, bit o, bit last_rsp);
    int k = (n < 1) ? 1 : n;
    for (int i = 0; i < k; i++) begin
      slot_t s;
      s.cle = c; s.ale = a; s.we_n = w; s.re_n = r; s.oe = o;
      s.rsp_after = last_rsp && (i == k - 1);
      q.push_back(s);
    end
  endtask

  // kind: 0 command, 1 address, 2 data write, 3 data read
  task automatic build(int kind, logic [7:0] b);
    int wp = m_time[3:0], wh = m_time[7:4], rp = m_time[11:8], reh = m_time[15:12];
    int rhz = m_time[18:16], wb = m_time[23:19], cea = m_time[25:24];
    if (m_ce && cea != 0) push_n(cea, 0, 0, 1, 1, 0, 0);
    if (kind == 3) begin
      push_n(rp, 0, 0, 1, 0, 0, 0);
      push_n((reh > rhz) ? reh : rhz, 0, 0, 1, 1, 0, 1);
      m_rd_op = 1;
    end else begin
      push_n(wp, kind == 0, kind == 1, 0, 1, 1, 0);
      push_n(wh, kind == 0, kind == 1, 1, 1, 1, 0);
      if (kind == 0) begin
        push_n(wb, 0, 0, 1, 1, 0, 0);
        wait_rb = 1;
      end
      m_rd_op = 0;
      m_byte = b;
    end
  endtask

  task automatic cyc();
    bit busy, eng, exp_ready, nrsp, bad;
    logic [31:0] ndata;
    logic [8:0] got, expv;
    slot_t s;
    #1;
    busy = (q.size() != 0) || wait_rb;
    if (q.size() != 0) s = q[0];
    else begin s.cle = 0; s.ale = 0; s.we_n = 1; s.re_n = 1; s.oe = 0; s.rsp_after = 0; end
    eng = req_write ? (req_addr <= 3'd2) : (req_addr == 3'd2);
    exp_ready = !(busy && (eng || (!req_write && m_rd_op)));
    got  = {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_ce_n, ctrl_ready, req_ready, rsp_valid};
    expv = {s.cle, s.ale, s.we_n, s.re_n, s.oe, !(busy || !m_ce), !busy, exp_ready, cur_rsp};
    bad = (got !== expv) || (s.oe && nand_dq_out !== m_byte) || (cur_rsp && rsp_rdata !== cur_data);
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s t=%0t pins got %b exp %b dq got %h exp %h rdata got %h exp %h",
               tag, $time, got, expv, nand_dq_out, m_byte, rsp_rdata, cur_data);
    end
    nrsp = 0; ndata = '0;
    if (q.size() != 0) begin
      s = q.pop_front();
      if (s.rsp_after) begin nrsp = 1; ndata = {24'd0, m_rbyte}; end
    end else if (wait_rb && nand_rb) begin
      wait_rb = 0;
    end
    last_acc = req_valid && exp_ready;
    if (last_acc) begin
      if (req_write) begin
        case (req_addr)
          3'd0: begin if (req_wdata[7:0] == 8'hFF) m_armed = 0; build(0, req_wdata[7:0]); end
          3'd1: build(1, req_wdata[7:0]);
          3'd2: build(2, req_wdata[7:0]);
          3'd3: begin if (m_armed) m_cfg = req_wdata[3:0]; m_armed = 0; end
          3'd4: begin if (m_armed) m_time = req_wdata[25:0]; m_armed = 0; end
          3'd5: m_armed = (req_wdata == KEYV);
          3'd6: m_ce = req_wdata[0];
          default: ;
        endcase
      end else if (req_addr == 3'd2) begin
        m_rbyte = nand_dq_in;
        build(3, 8'h00);
      end else begin
        nrsp = 1;
        case (req_addr)
          3'd3: ndata = {28'd0, m_cfg};
          3'd4: ndata = {6'd0, m_time};
          3'd6: ndata = {31'd0, m_ce};
          3'd7: ndata = {30'd0, !busy, nand_rb};
          default: ndata = '0;
        endcase
      end
    end
    cur_rsp = nrsp; cur_data = ndata;
    @(negedge clk);
  endtask

  task automatic req(bit w, logic [2:0] a, logic [31:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do cyc(); while (!last_acc);
    req_valid = 0;
  endtask

  task automatic settle();
    while (q.size() != 0 || wait_rb || cur_rsp) cyc();
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, got hang exp finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; tag = "R1";
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    nand_dq_in = 8'h00; nand_rb = 1;
    wait_rb = 0; m_rd_op = 0; m_armed = 0; m_ce = 1; cur_rsp = 0; cur_data = '0;
    m_cfg = '0; m_time = TRST; m_byte = '0; m_rbyte = '0; last_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle pins and reset register values
    cyc(); cyc();
    req(0, 3'd3, 0); req(0, 3'd4, 0); req(0, 3'd6, 0); req(0, 3'd7, 0); settle();
    // R2: command cycle with reset timing
    tag = "R2"; req(1, 3'd0, 32'h90); settle();
    // R4: data write cycle
    tag = "R4"; req(1, 3'd2, 32'hA5); settle();
    // R7: protected write without key is ignored, key is single-use
    tag = "R7";
    req(1, 3'd4, {6'd0, pack(3, 2, 4, 1, 5, 3, 2)}); req(0, 3'd4, 0);
    req(1, 3'd5, KEYV); req(1, 3'd4, {6'd0, pack(3, 2, 4, 1, 5, 3, 2)});
    req(1, 3'd4, 32'h0); req(0, 3'd4, 0); settle();
    // R3 and R6: address cycle with a two-clock setup phase
    tag = "R3"; req(1, 3'd1, 32'h1234_56AB); settle();
    // R5: read with read-to-high-Z longer than read hold
    tag = "R5"; nand_dq_in = 8'h5A; req(0, 3'd2, 0); settle();
    // R12: configuration bits stored, bus still 8 bits
    tag = "R12"; req(1, 3'd5, KEYV); req(1, 3'd3, 32'hF); req(0, 3'd3, 0);
    req(1, 3'd2, 32'hBEEF_C3); settle();
    // R9: forced chip enable, no setup phase
    tag = "R9"; req(1, 3'd6, 0); cyc(); cyc(); req(1, 3'd2, 32'h3C); settle();
    req(0, 3'd6, 0); req(1, 3'd6, 1); cyc(); cyc();
    // R10 and R11: ready wait, status read while busy, stalled bus write
    tag = "R10"; nand_rb = 0; req(1, 3'd0, 32'h70); repeat (6) cyc();
    req(0, 3'd7, 0); cyc(); cyc();
    tag = "R11"; req_valid = 1; req_write = 1; req_addr = 3'd2; req_wdata = 32'h55;
    repeat (4) cyc();
    nand_rb = 1;
    do cyc(); while (!last_acc);
    req_valid = 0; settle();
    // R11: register read stalls while a data read runs
    nand_dq_in = 8'hA7; req(0, 3'd2, 0); req(0, 3'd3, 0); settle();
    // R8: reset command withdraws the key
    tag = "R8"; req(1, 3'd5, KEYV); req(1, 3'd0, 32'hFF); settle();
    req(1, 3'd4, 32'h0); req(0, 3'd4, 0); settle();
    // R7: wrong key value
    tag = "R7"; req(1, 3'd5, 32'h1234); req(1, 3'd3, 0); req(0, 3'd3, 0); settle();
    // R6: all-zero timing gives one clock per phase
    tag = "R6"; req(1, 3'd5, KEYV); req(1, 3'd4, 0); req(1, 3'd0, 32'h00); settle();
    nand_dq_in = 8'h81; req(0, 3'd2, 0); settle();
    req(1, 3'd1, 32'h7E); settle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule